// File: doc/BRIEF.md
# Program Memory Security Guard

This block sits between the requesters of on-chip program memory and the memory itself. It decides which of those accesses may proceed. It holds three lock bits, a 64-entry key array and a watchdog power-up option bit. The three lock bits select one of four cumulative protection levels. Every request is answered one cycle later with either a grant pulse or a refusal pulse. The request kinds are a verify read, a read of internal code by externally running code, an external data read of internal SRAM, an external fetch, and a programming write.

A granted verify read returns the flash byte XNORed with the key byte that the low six address bits select, so the key pattern repeats every 64 bytes. While every key byte is still FFh, the data comes back in plain form. The lock bits, the key bytes and the option bit can only have bits cleared by programming. A mass erase returns all of them to the erased state in one cycle. The flash array, the programming pulse timing and the loader protocol are outside this block. They appear only as data and request ports.

Top module: `fsec_guard`

## Requirements
- R1: The lock bits are held as {LB3,LB2,LB1}, programmed from data bits [2:0] in that order. `lvl_o` reports the protection level minus one. LB3=0 gives 3, whatever LB2 and LB1 hold. Otherwise LB2=0 gives 2, whatever LB1 holds. Otherwise LB1=0 gives 1. All three at 1 gives 0.
- R2: A lock write uses target code 0. It is always granted, from either path and at any level. It ANDs the data into the lock bits, so writing 1s never lowers the level.
- R3: A one-cycle `mass_erase_i` does four things on the next edge: it sets all lock bits to 1, all key bytes to FFh and the option bit to 1, and it takes priority over a program write in the same cycle. After reset the block is in this erased state: level 0, encryption off, watchdog power-up enable low, no pulses, `rdata_o`=FFh.
- R4: A granted flash verify (`vfy_sec_i`=0) returns ~(flash ^ key[addr[5:0]]). `crypt_on_o` is high exactly when some key byte differs from FFh. While the array is all FFh, the data is returned unchanged.
- R5: A flash verify is granted at levels 0 and 1 and refused at levels 2 and 3.
- R6: A read of internal code by external code (`movc_req_i`) is granted only at level 0. It returns the flash byte without encryption.
- R7: An external data read of internal SRAM is granted at levels 0 and 1 and returns `sram_rdata_i`. It is refused at levels 2 and 3.
- R8: An external fetch is refused only at level 3.
- R9: A key write (target 1), an option write (target 2) or an option erase (target 3) from the parallel or loader path (`prog_ext_i`=1) is refused at levels 1 to 3. From the in-application path (`prog_ext_i`=0) these writes are always granted.
- R10: The response arrives one cycle after the request. `done_o` or `deny_o` pulses for exactly that cycle, and never both together. `rdata_o` is FFh on a refusal, on a grant with no read data, and when idle.
- R11: Option bit 3 is ANDed with data bit 3 on a target-2 write and set to 1 on a target-3 erase. A security-space verify (`vfy_sec_i`=1) at address FCh is granted at every level and returns a byte of 1s that carries the option bit in bit 3, without encryption. Any other security-space address returns FFh. `wdt_por_en_o` is the inverse of the option bit.
- R12: A key write ANDs the data into the addressed byte, so a bit cleared to 0 stays 0 until a mass erase. Once encryption is on, it stays on until a mass erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mass_erase_i | input | 1 | Erase all security state |
| prog_req_i | input | 1 | Programming write request |
| prog_ext_i | input | 1 | 1: parallel/loader path, 0: in-application path |
| prog_tgt_i | input | 2 | 0 lock, 1 key byte, 2 option write, 3 option erase |
| prog_addr_i | input | 6 | Key byte index |
| prog_data_i | input | 8 | Write data |
| vfy_req_i | input | 1 | Verify read request |
| vfy_sec_i | input | 1 | 1: security space, 0: program flash |
| vfy_addr_i | input | 16 | Verify address |
| flash_rdata_i | input | 8 | Flash byte at the requested address |
| movc_req_i | input | 1 | External code reads internal program memory |
| sram_rdata_i | input | 8 | Internal SRAM byte for an external data read |
| xram_req_i | input | 1 | External data read of internal SRAM |
| xexec_req_i | input | 1 | External code fetch request |
| done_o | output | 1 | Grant pulse |
| deny_o | output | 1 | Refusal pulse |
| rdata_o | output | 8 | Response data |
| lvl_o | output | 2 | Protection level minus one |
| crypt_on_o | output | 1 | Key array programmed |
| wdt_por_en_o | output | 1 | Watchdog reset enabled at power-up |

## Verification
The assertions assume that at most one of the five request inputs is high in any cycle. The fixed priority among them is a safety net and not part of the contract. The response-gating properties rely on that single-request rule to tie a refusal or grant to one request kind. The stimulus presents exactly one request per cycle. Mass erase is raised either alone or together with a lock write, and that pairing is used only to check that erase wins.

// File: rtl/fsec_pkg.sv
package fsec_pkg;

    localparam int BYTE_W  = 8;
    localparam int LOCK_W  = 3;

    typedef enum logic [1:0] {
        TGT_LOCK    = 2'd0,
        TGT_KEY     = 2'd1,
        TGT_OPT     = 2'd2,
        TGT_OPT_CLR = 2'd3
    } prog_tgt_e;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'd0,
        LVL_NOREAD = 2'd1,
        LVL_NOVFY  = 2'd2,
        LVL_NOEXEC = 2'd3
    } lvl_e;

    typedef struct packed {
        logic              done;
        logic              deny;
        logic [BYTE_W-1:0] rdata;
    } rsp_t;

    // lb = {LB3, LB2, LB1}; a cleared higher bit dominates the lower ones
    function automatic lvl_e lvl_decode(input logic [LOCK_W-1:0] lb);
        lvl_e l;
        if (!lb[2])      l = LVL_NOEXEC;
        else if (!lb[1]) l = LVL_NOVFY;
        else if (!lb[0]) l = LVL_NOREAD;
        else             l = LVL_OPEN;
        return l;
    endfunction

endpackage

// File: rtl/fsec_lock_bank.sv
module fsec_lock_bank
    import fsec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              wr_i,
    input  logic [LOCK_W-1:0] wr_bits_i,
    output lvl_e              lvl_o
);

    typedef struct packed {
        logic [LOCK_W-1:0] lb;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (erase_i)   st_d.lb = '1;
        else if (wr_i) st_d.lb = st_q.lb & wr_bits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lb: '1};
        else        st_q <= st_d;
    end

    assign lvl_o = lvl_decode(st_q.lb);

    // R2: without an erase no lock bit may go from 0 back to 1
    p_lock_no_relax_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_i |=> ((st_q.lb & ~$past(st_q.lb)) == '0));

    // R3: erase leaves every lock bit at 1
    p_lock_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (lvl_o == LVL_OPEN));

endmodule

// File: rtl/fsec_key_bank.sv
module fsec_key_bank
    import fsec_pkg::*;
#(
    parameter int KEY_N = 64,
    localparam int KIW  = $clog2(KEY_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              wr_i,
    input  logic [KIW-1:0]    wr_idx_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [KIW-1:0]    rd_idx_i,
    output logic [BYTE_W-1:0] key_o,
    output logic              crypt_on_o
);

    typedef struct packed {
        logic [KEY_N-1:0][BYTE_W-1:0] keys;
    } key_st_t;

    key_st_t          st_d, st_q;
    logic [KEY_N-1:0] byte_used;

    always_comb begin
        st_d = st_q;
        if (erase_i)   st_d.keys = '1;
        else if (wr_i) st_d.keys[wr_idx_i] = st_q.keys[wr_idx_i] & wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    // one flag per key byte: has any bit of it been cleared
    for (genvar g = 0; g < KEY_N; g++) begin : g_used
        assign byte_used[g] = (st_q.keys[g] != {BYTE_W{1'b1}});
    end

    assign crypt_on_o = |byte_used;
    assign key_o      = st_q.keys[rd_idx_i];

    // R12: AND-only writes cannot restore an all-FFh array
    p_crypt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (crypt_on_o && !erase_i) |=> crypt_on_o);

    // R3: erase switches encryption off
    p_crypt_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> !crypt_on_o);

endmodule

// File: rtl/fsec_opt_reg.sv
module fsec_opt_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_i,
    input  logic clr_i,
    input  logic wr_i,
    input  logic bit_i,
    output logic bit_o
);

    typedef struct packed {
        logic wdt_off;
    } opt_st_t;

    opt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (erase_i || clr_i) st_d.wdt_off = 1'b1;
        else if (wr_i)        st_d.wdt_off = st_q.wdt_off & bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wdt_off: 1'b1};
        else        st_q <= st_d;
    end

    assign bit_o = st_q.wdt_off;

    // R11: the option bit rises only through an erase
    p_opt_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase_i && !clr_i) |=> !$rose(bit_o));

endmodule

// File: rtl/fsec_guard.sv
module fsec_guard
    import fsec_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter int                 KEY_N    = 64,
    parameter logic [ADDR_W-1:0]  OPT_ADDR = 'hFC,
    parameter int                 OPT_BIT  = 3,
    localparam int                KIW      = $clog2(KEY_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mass_erase_i,
    input  logic              prog_req_i,
    input  logic              prog_ext_i,
    input  logic [1:0]        prog_tgt_i,
    input  logic [KIW-1:0]    prog_addr_i,
    input  logic [BYTE_W-1:0] prog_data_i,
    input  logic              vfy_req_i,
    input  logic              vfy_sec_i,
    input  logic [ADDR_W-1:0] vfy_addr_i,
    input  logic [BYTE_W-1:0] flash_rdata_i,
    input  logic              movc_req_i,
    input  logic [BYTE_W-1:0] sram_rdata_i,
    input  logic              xram_req_i,
    input  logic              xexec_req_i,
    output logic              done_o,
    output logic              deny_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [1:0]        lvl_o,
    output logic              crypt_on_o,
    output logic              wdt_por_en_o
);

    lvl_e              lvl;
    logic [BYTE_W-1:0] key_rd;
    logic              crypt_on;
    logic              opt_bit;

    logic              prog_sel;
    logic              prog_ok;
    prog_tgt_e         tgt;
    logic              lock_wr, key_wr, opt_wr, opt_clr;
    logic [BYTE_W-1:0] opt_byte;
    logic [BYTE_W-1:0] vfy_data;

    rsp_t rsp_d, rsp_q;

    assign tgt = prog_tgt_e'(prog_tgt_i);

    // programming is lowest priority; lock writes are never refused
    always_comb begin
        prog_sel = prog_req_i & ~(vfy_req_i | movc_req_i | xram_req_i | xexec_req_i);
        prog_ok  = (tgt == TGT_LOCK) || !prog_ext_i || (lvl == LVL_OPEN);
        lock_wr  = prog_sel && (tgt == TGT_LOCK);
        key_wr   = prog_sel && prog_ok && (tgt == TGT_KEY);
        opt_wr   = prog_sel && prog_ok && (tgt == TGT_OPT);
        opt_clr  = prog_sel && prog_ok && (tgt == TGT_OPT_CLR);
    end

    fsec_lock_bank u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_i   (mass_erase_i),
        .wr_i      (lock_wr),
        .wr_bits_i (prog_data_i[LOCK_W-1:0]),
        .lvl_o     (lvl)
    );

    fsec_key_bank #(.KEY_N(KEY_N)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_i    (mass_erase_i),
        .wr_i       (key_wr),
        .wr_idx_i   (prog_addr_i),
        .wr_data_i  (prog_data_i),
        .rd_idx_i   (vfy_addr_i[KIW-1:0]),
        .key_o      (key_rd),
        .crypt_on_o (crypt_on)
    );

    fsec_opt_reg u_opt (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase_i (mass_erase_i),
        .clr_i   (opt_clr),
        .wr_i    (opt_wr),
        .bit_i   (prog_data_i[OPT_BIT]),
        .bit_o   (opt_bit)
    );

    always_comb begin
        opt_byte          = '1;
        opt_byte[OPT_BIT] = opt_bit;
        vfy_data          = crypt_on ? ~(flash_rdata_i ^ key_rd) : flash_rdata_i;
    end

    always_comb begin
        rsp_d = '{done: 1'b0, deny: 1'b0, rdata: '1};
        if (vfy_req_i) begin
            if (vfy_sec_i) begin
                rsp_d.done  = 1'b1;
                rsp_d.rdata = (vfy_addr_i == OPT_ADDR) ? opt_byte : '1;
            end else if (lvl >= LVL_NOVFY) begin
                rsp_d.deny  = 1'b1;
            end else begin
                rsp_d.done  = 1'b1;
                rsp_d.rdata = vfy_data;
            end
        end else if (movc_req_i) begin
            if (lvl == LVL_OPEN) begin
                rsp_d.done  = 1'b1;
                rsp_d.rdata = flash_rdata_i;
            end else begin
                rsp_d.deny  = 1'b1;
            end
        end else if (xram_req_i) begin
            if (lvl <= LVL_NOREAD) begin
                rsp_d.done  = 1'b1;
                rsp_d.rdata = sram_rdata_i;
            end else begin
                rsp_d.deny  = 1'b1;
            end
        end else if (xexec_req_i) begin
            rsp_d.done = (lvl != LVL_NOEXEC);
            rsp_d.deny = (lvl == LVL_NOEXEC);
        end else if (prog_sel) begin
            rsp_d.done = prog_ok;
            rsp_d.deny = !prog_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '{done: 1'b0, deny: 1'b0, rdata: '1};
        else        rsp_q <= rsp_d;
    end

    assign done_o       = rsp_q.done;
    assign deny_o       = rsp_q.deny;
    assign rdata_o      = rsp_q.rdata;
    assign lvl_o        = lvl;
    assign crypt_on_o   = crypt_on;
    assign wdt_por_en_o = !opt_bit;

    // R10: input contract, at most one request per cycle
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vfy_req_i, movc_req_i, xram_req_i, xexec_req_i, prog_req_i}));

    // R10: grant and refusal are exclusive, refusal carries FFh
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && deny_o));
    p_deny_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> (rdata_o == '1));

    // R5: flash verify refused at the two top levels
    p_vfy_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vfy_req_i && !vfy_sec_i && lvl_o >= 2'd2) |=> deny_o);

    // R6: external code read refused above level 0
    p_movc_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (movc_req_i && lvl_o != 2'd0) |=> deny_o);

    // R8: external fetch granted below the top level
    p_xexec_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xexec_req_i && lvl_o != 2'd3) |=> done_o);

    // R2: a lone lock write is always granted
    p_lock_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_i && prog_tgt_i == 2'd0 && !vfy_req_i && !movc_req_i
         && !xram_req_i && !xexec_req_i) |=> done_o);

    // R11: option readback is granted at every level
    p_opt_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vfy_req_i && vfy_sec_i) |=> done_o);

endmodule

// File: tb/fsec_guard_tb.sv
module fsec_guard_tb;
    import fsec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mass_erase_i = 1'b0;
    logic        prog_req_i = 1'b0;
    logic        prog_ext_i = 1'b0;
    logic [1:0]  prog_tgt_i = '0;
    logic [5:0]  prog_addr_i = '0;
    logic [7:0]  prog_data_i = '0;
    logic        vfy_req_i = 1'b0;
    logic        vfy_sec_i = 1'b0;
    logic [15:0] vfy_addr_i = '0;
    logic [7:0]  flash_rdata_i = '0;
    logic        movc_req_i = 1'b0;
    logic [7:0]  sram_rdata_i = '0;
    logic        xram_req_i = 1'b0;
    logic        xexec_req_i = 1'b0;
    logic        done_o, deny_o;
    logic [7:0]  rdata_o;
    logic [1:0]  lvl_o;
    logic        crypt_on_o, wdt_por_en_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    fsec_guard u_dut (
        .clk(clk), .rst_n(rst_n), .mass_erase_i(mass_erase_i),
        .prog_req_i(prog_req_i), .prog_ext_i(prog_ext_i), .prog_tgt_i(prog_tgt_i),
        .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i),
        .vfy_req_i(vfy_req_i), .vfy_sec_i(vfy_sec_i), .vfy_addr_i(vfy_addr_i),
        .flash_rdata_i(flash_rdata_i), .movc_req_i(movc_req_i),
        .sram_rdata_i(sram_rdata_i), .xram_req_i(xram_req_i), .xexec_req_i(xexec_req_i),
        .done_o(done_o), .deny_o(deny_o), .rdata_o(rdata_o), .lvl_o(lvl_o),
        .crypt_on_o(crypt_on_o), .wdt_por_en_o(wdt_por_en_o)
    );

    localparam logic [3:0] OP_IDLE = 4'd0, OP_VFY = 4'd1, OP_VSEC = 4'd2,
                           OP_MOVC = 4'd3, OP_XRAM = 4'd4, OP_XEXEC = 4'd5,
                           OP_PINT = 4'd6, OP_PEXT = 4'd7;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  tgt;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  flash;
        logic        edone;
        logic        edeny;
        logic [7:0]  erd;
        logic [1:0]  elvl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{OP_VFY,  2'd0, 16'h0010, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h5A, 2'd0, 8'd4},  // R4 plain
        '{OP_VSEC, 2'd0, 16'h00FC, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd0, 8'd11}, // R11
        '{OP_MOVC, 2'd0, 16'h0000, 8'h00, 8'h3C, 1'b1, 1'b0, 8'h3C, 2'd0, 8'd6},  // R6
        '{OP_XRAM, 2'd0, 16'h0000, 8'h77, 8'h00, 1'b1, 1'b0, 8'h77, 2'd0, 8'd7},  // R7
        '{OP_XEXEC,2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd0, 8'd8},  // R8
        '{OP_PEXT, 2'd1, 16'h0005, 8'hF0, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd0, 8'd9},  // R9
        '{OP_VFY,  2'd0, 16'h0045, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h55, 2'd0, 8'd4},  // R4 xnor
        '{OP_VFY,  2'd0, 16'h0046, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h5A, 2'd0, 8'd4},
        '{OP_PINT, 2'd1, 16'h0005, 8'h3F, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd0, 8'd12}, // R12
        '{OP_VFY,  2'd0, 16'h0105, 8'h00, 8'h00, 1'b1, 1'b0, 8'hCF, 2'd0, 8'd12},
        '{OP_PINT, 2'd1, 16'h0005, 8'hFF, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd0, 8'd12},
        '{OP_VFY,  2'd0, 16'h0005, 8'h00, 8'h00, 1'b1, 1'b0, 8'hCF, 2'd0, 8'd12},
        '{OP_PINT, 2'd2, 16'h0000, 8'hF7, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd0, 8'd11},
        '{OP_VSEC, 2'd0, 16'h00FC, 8'h00, 8'h00, 1'b1, 1'b0, 8'hF7, 2'd0, 8'd11},
        '{OP_VSEC, 2'd0, 16'h00FD, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd0, 8'd11},
        '{OP_PINT, 2'd0, 16'h0000, 8'hFE, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd1, 8'd1},  // R1
        '{OP_MOVC, 2'd0, 16'h0000, 8'h00, 8'h3C, 1'b0, 1'b1, 8'hFF, 2'd1, 8'd6},
        '{OP_VFY,  2'd0, 16'h0006, 8'h00, 8'h12, 1'b1, 1'b0, 8'h12, 2'd1, 8'd5},  // R5
        '{OP_PEXT, 2'd1, 16'h0006, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 2'd1, 8'd9},
        '{OP_PINT, 2'd1, 16'h0006, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd1, 8'd9},
        '{OP_VFY,  2'd0, 16'h0006, 8'h00, 8'h12, 1'b1, 1'b0, 8'hED, 2'd1, 8'd4},
        '{OP_XRAM, 2'd0, 16'h0000, 8'h44, 8'h00, 1'b1, 1'b0, 8'h44, 2'd1, 8'd7},
        '{OP_PEXT, 2'd0, 16'h0000, 8'hFF, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd1, 8'd2},  // R2
        '{OP_PEXT, 2'd0, 16'h0000, 8'hFD, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd2, 8'd1},
        '{OP_VFY,  2'd0, 16'h0006, 8'h00, 8'h12, 1'b0, 1'b1, 8'hFF, 2'd2, 8'd5},
        '{OP_XRAM, 2'd0, 16'h0000, 8'h44, 8'h00, 1'b0, 1'b1, 8'hFF, 2'd2, 8'd7},
        '{OP_XEXEC,2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd2, 8'd8},
        '{OP_VSEC, 2'd0, 16'h00FC, 8'h00, 8'h00, 1'b1, 1'b0, 8'hF7, 2'd2, 8'd11},
        '{OP_PEXT, 2'd3, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 2'd2, 8'd9},
        '{OP_PINT, 2'd3, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd2, 8'd11},
        '{OP_VSEC, 2'd0, 16'h00FC, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd2, 8'd11},
        '{OP_PINT, 2'd0, 16'h0000, 8'hFB, 8'h00, 1'b1, 1'b0, 8'hFF, 2'd3, 8'd1},
        '{OP_XEXEC,2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 2'd3, 8'd8},
        '{OP_MOVC, 2'd0, 16'h0000, 8'h00, 8'h3C, 1'b0, 1'b1, 8'hFF, 2'd3, 8'd6},
        '{OP_IDLE, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 2'd3, 8'd10}  // R10
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        mass_erase_i = 1'b0; prog_req_i = 1'b0; prog_ext_i = 1'b0;
        vfy_req_i = 1'b0; vfy_sec_i = 1'b0; movc_req_i = 1'b0;
        xram_req_i = 1'b0; xexec_req_i = 1'b0;
    endtask

    // drive after the falling edge, sample 2 ns after the rising edge
    task automatic apply(input vec_t v, input logic erase);
        @(negedge clk);
        vfy_req_i     = (v.op == OP_VFY) || (v.op == OP_VSEC);
        vfy_sec_i     = (v.op == OP_VSEC);
        movc_req_i    = (v.op == OP_MOVC);
        xram_req_i    = (v.op == OP_XRAM);
        xexec_req_i   = (v.op == OP_XEXEC);
        prog_req_i    = (v.op == OP_PINT) || (v.op == OP_PEXT);
        prog_ext_i    = (v.op == OP_PEXT);
        prog_tgt_i    = v.tgt;
        prog_addr_i   = v.addr[5:0];
        vfy_addr_i    = v.addr;
        prog_data_i   = v.wdata;
        sram_rdata_i  = v.wdata;
        flash_rdata_i = v.flash;
        mass_erase_i  = erase;
        @(posedge clk);
        #2;
        clear_inputs();
    endtask

    function automatic vec_t mk(input logic [3:0] op, input logic [1:0] tgt,
                                input logic [15:0] addr, input logic [7:0] wd,
                                input logic [7:0] fl);
        vec_t v = '0;
        v.op = op; v.tgt = tgt; v.addr = addr; v.wdata = wd; v.flash = fl;
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R3: erased state out of reset
        check("R3", "reset done",  {15'd0, done_o},  16'd0);
        check("R3", "reset deny",  {15'd0, deny_o},  16'd0);
        check("R3", "reset rdata", {8'd0, rdata_o},  16'h00FF);
        check("R3", "reset lvl",   {14'd0, lvl_o},   16'd0);
        check("R3", "reset crypt", {15'd0, crypt_on_o}, 16'd0);
        check("R3", "reset wdt",   {15'd0, wdt_por_en_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            apply(VECS[i], 1'b0);
            rq = $sformatf("R%0d", VECS[i].req);
            check(rq, $sformatf("vec%0d done", i),  {15'd0, done_o}, {15'd0, VECS[i].edone});
            check(rq, $sformatf("vec%0d deny", i),  {15'd0, deny_o}, {15'd0, VECS[i].edeny});
            check(rq, $sformatf("vec%0d rdata", i), {8'd0, rdata_o}, {8'd0, VECS[i].erd});
            check(rq, $sformatf("vec%0d lvl", i),   {14'd0, lvl_o},  {14'd0, VECS[i].elvl});
        end

        // R4 / R11: state left by the table
        check("R4",  "crypt on",      {15'd0, crypt_on_o},   16'd1);
        check("R11", "wdt after clr", {15'd0, wdt_por_en_o}, 16'd0);

        // R3: mass erase returns everything to erased values
        apply(mk(OP_IDLE, 2'd0, 16'h0, 8'h0, 8'h0), 1'b1);
        check("R3", "erase lvl",   {14'd0, lvl_o},      16'd0);
        check("R3", "erase crypt", {15'd0, crypt_on_o}, 16'd0);
        apply(mk(OP_VFY, 2'd0, 16'h0005, 8'h0, 8'h00), 1'b0);
        check("R3", "erased key plain", {8'd0, rdata_o}, 16'h0000);

        // R11: programming bit 3 low enables the power-up watchdog
        apply(mk(OP_PINT, 2'd2, 16'h0, 8'hF7, 8'h0), 1'b0);
        check("R11", "wdt enabled", {15'd0, wdt_por_en_o}, 16'd1);

        // R1: LB3 alone cleared gives the top level
        apply(mk(OP_PINT, 2'd0, 16'h0, 8'hFB, 8'h0), 1'b0);
        check("R1", "LB3 only", {14'd0, lvl_o}, 16'd3);

        // R3: erase wins over a lock write in the same cycle
        apply(mk(OP_PINT, 2'd0, 16'h0, 8'hFE, 8'h0), 1'b1);
        check("R3", "erase priority", {14'd0, lvl_o}, 16'd0);

        // R1: LB2 cleared with LB1 still 1
        apply(mk(OP_PINT, 2'd0, 16'h0, 8'hFD, 8'h0), 1'b0);
        check("R1", "LB2 only", {14'd0, lvl_o}, 16'd2);

        // R10: response pulse lasts one cycle
        apply(mk(OP_XEXEC, 2'd0, 16'h0, 8'h0, 8'h0), 1'b0);
        check("R10", "pulse high", {15'd0, done_o}, 16'd1);
        @(posedge clk); #2;
        check("R10", "pulse gone", {15'd0, done_o}, 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule